// File: doc/BRIEF.md
# PWM Timebase With Extended Period Counter

This block is the time reference for a pulse-width modulation unit. A main up-counter runs from a programmable start value to a programmable reload value and then restarts. A second, narrower counter counts the main counter's periods, so that slower events can be derived from the same timebase without another wide counter. Both count values go out as ports, where neighbouring compare logic can use them.

The block raises three sticky status flags: one for a main-counter reload, one at the half-period point, and one for an extended-counter reload. Software clears a flag by writing a one to it. Two enable masks with the same bit layout route the flags onto a single interrupt line and a single DMA request line. An external sync input can force a reload of both counters, and a timer-reset command reloads them without raising any flag.

Counting is governed by a two-state machine:

- `ST_HALT`: the counts are held and no flag is set.
- `ST_RUN`: the counters advance.

The START transition (`ST_HALT` to `ST_RUN`) is taken when the enable input is sampled high. The STOP transition (`ST_RUN` to `ST_HALT`) is taken when it is sampled low. Each state otherwise remains where it is.

Top module: `pwm_timebase`

## Requirements
- R1: In `ST_RUN`, with no sync event and no timer reset, the main counter increments by one each cycle. In the cycle where it is equal to or above `cnt_reload`, it instead loads `cnt_start` and sets status bit 0 (reload flag).
- R2: Status bit 1 (half flag) is set when the main counter advances in `ST_RUN` while it equals `cnt_reload` shifted right by one. Division rounds down.
- R3: The extended counter steps by one on each main-counter reload. On a reload where it is equal to or above `xcnt_reload`, it instead loads `xcnt_start` and sets status bit 2 (extended reload flag).
- R4: In `ST_RUN` with `sync_en` high, a rising edge on `sync_in` forces both reloads. The main counter loads `cnt_start` and the extended counter loads `xcnt_start`. Status bits 0 and 2 are set; bit 1 is not set by the event.
- R5: A one in bit n of `status_clr` clears status bit n at the next edge. If the same bit is being set in that cycle, the set wins.
- R6: `irq_o` is high exactly when some status bit and the same bit of `irq_mask` are both one. It follows status and mask changes in the same cycle.
- R7: `dma_o` is high exactly when some status bit and the same bit of `dma_mask` are both one. It follows status and mask changes in the same cycle.
- R8: The state becomes `ST_RUN` at the edge where `run_en` is sampled high and `ST_HALT` where it is sampled low. Counting starts one cycle after `run_en` rises. In `ST_HALT` both counts hold, no flag is set, and `sync_in` is ignored.
- R9: After reset both counts are 0, all status bits are 0, and the state is `ST_HALT`.
- R10: `tmr_rst` high at an edge, in either state, loads `cnt_start` and `xcnt_start` and sets no flag. It takes priority over a sync event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter enable |
| sync_en | input | 1 | Allows `sync_in` edges to force reloads |
| sync_in | input | 1 | External sync, rising edge active |
| tmr_rst | input | 1 | Timer-reset command |
| cnt_start | input | CW | Main counter start value |
| cnt_reload | input | CW | Main counter reload value |
| xcnt_start | input | XW | Extended counter start value |
| xcnt_reload | input | XW | Extended counter reload value |
| status_clr | input | 3 | Write-1-to-clear strobes for the status bits |
| irq_mask | input | 3 | Interrupt enable per status bit |
| dma_mask | input | 3 | DMA request enable per status bit |
| cnt_o | output | CW | Main count value |
| xcnt_o | output | XW | Extended count value |
| status_o | output | 3 | Status: bit 0 reload, bit 1 half, bit 2 extended reload |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |

## Verification
A wrong count shows up on `cnt_o` at the very next edge. It then shifts every later reload, so status bit 0 and the request lines go out of step within one period. A wrong extended count, or a missed sync edge, is visible on `xcnt_o` and on status bit 2 no later than the next main reload. A lost set-wins-over-clear ordering leaves a status bit low one cycle after a simultaneous set and clear. A state register stuck in the wrong state shows as counts moving, or failing to move, one cycle after `run_en` changes. Random stimulus with frequent clears, syncs and short periods is compared every cycle against a bench model, so each of these faults becomes visible within a few cycles of its cause.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tb_state_e;

    localparam int NFLAG    = 3;
    localparam int FLG_RLD  = 0;
    localparam int FLG_HALF = 1;
    localparam int FLG_XRLD = 2;
endpackage

// File: rtl/pwm_tb_fsm.sv
module pwm_tb_fsm
    import pwm_tb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic running
);
    tb_state_e state_q, state_d;

    // next-state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_HALT));
    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (state_q == ST_RUN));
endmodule

// File: rtl/pwm_tb_main.sv
module pwm_tb_main #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          half_hit
);
    logic [CW-1:0] half_pt;

    always_comb begin
        half_pt  = reload >> 1;
        wrap     = adv && (cnt >= reload);
        half_hit = adv && (cnt == half_pt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= start;
        else if (wrap)  cnt <= start;
        else if (adv)   cnt <= cnt + 1'b1;
    end

    p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == $past(start)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(cnt));
endmodule

// File: rtl/pwm_tb_ext.sv
module pwm_tb_ext #(
    parameter int XW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [XW-1:0] xstart,
    input  logic [XW-1:0] xreload,
    output logic [XW-1:0] xcnt,
    output logic          xwrap
);
    always_comb begin
        xwrap = step && (xcnt >= xreload);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     xcnt <= '0;
        else if (load)  xcnt <= xstart;
        else if (xwrap) xcnt <= xstart;
        else if (step)  xcnt <= xcnt + 1'b1;
    end

    p_ext_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !xwrap && !load) |=> (xcnt == $past(xcnt) + 1'b1));
    p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(xcnt));
endmodule

// File: rtl/pwm_tb_flags.sv
module pwm_tb_flags
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    input  logic [NFLAG-1:0] irq_mask,
    input  logic [NFLAG-1:0] dma_mask,
    output logic [NFLAG-1:0] status,
    output logic             irq_o,
    output logic             dma_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_v) | set_v;
    end

    always_comb begin
        irq_o = |(status & irq_mask);
        dma_o = |(status & dma_mask);
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
    p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & ~set_v)) |=> ((status & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16,
    parameter int XW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          sync_en,
    input  logic          sync_in,
    input  logic          tmr_rst,
    input  logic [CW-1:0] cnt_start,
    input  logic [CW-1:0] cnt_reload,
    input  logic [XW-1:0] xcnt_start,
    input  logic [XW-1:0] xcnt_reload,
    input  logic [2:0]    status_clr,
    input  logic [2:0]    irq_mask,
    input  logic [2:0]    dma_mask,
    output logic [CW-1:0] cnt_o,
    output logic [XW-1:0] xcnt_o,
    output logic [2:0]    status_o,
    output logic          irq_o,
    output logic          dma_o
);
    logic             running;
    logic             sync_q;
    logic             sync_hit;
    logic             adv;
    logic             load;
    logic             wrap;
    logic             half_hit;
    logic             xwrap;
    logic [NFLAG-1:0] set_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    always_comb begin
        sync_hit = running && sync_en && sync_in && !sync_q && !tmr_rst;
        load     = tmr_rst || sync_hit;
        adv      = running && !load;
        set_v              = '0;
        set_v[FLG_RLD]     = wrap || sync_hit;
        set_v[FLG_HALF]    = half_hit;
        set_v[FLG_XRLD]    = xwrap || sync_hit;
    end

    pwm_tb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .running (running)
    );

    pwm_tb_main #(.CW(CW)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .load     (load),
        .start    (cnt_start),
        .reload   (cnt_reload),
        .cnt      (cnt_o),
        .wrap     (wrap),
        .half_hit (half_hit)
    );

    pwm_tb_ext #(.XW(XW)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (wrap),
        .load    (load),
        .xstart  (xcnt_start),
        .xreload (xcnt_reload),
        .xcnt    (xcnt_o),
        .xwrap   (xwrap)
    );

    pwm_tb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_v    (set_v),
        .clr_v    (status_clr),
        .irq_mask (irq_mask),
        .dma_mask (dma_mask),
        .status   (status_o),
        .irq_o    (irq_o),
        .dma_o    (dma_o)
    );

    p_sync_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> ((cnt_o == $past(cnt_start)) && (xcnt_o == $past(xcnt_start))
                      && status_o[FLG_RLD] && status_o[FLG_XRLD]));
    p_timer_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst |=> ((cnt_o == $past(cnt_start)) && (xcnt_o == $past(xcnt_start))));
    p_halt_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(|status_clr)) |=> $stable(status_o));
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    localparam int CW = 16;
    localparam int XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0, sync_en = 1'b0, sync_in = 1'b0, tmr_rst = 1'b0;
    logic [CW-1:0] cnt_start = '0, cnt_reload = '0;
    logic [XW-1:0] xcnt_start = '0, xcnt_reload = '0;
    logic [2:0]    status_clr = '0, irq_mask = '0, dma_mask = '0;
    logic [CW-1:0] cnt_o;
    logic [XW-1:0] xcnt_o;
    logic [2:0]    status_o;
    logic          irq_o, dma_o;

    int vectors = 0;
    int fails   = 0;

    logic          m_run, m_syncq;
    logic [CW-1:0] m_cnt;
    logic [XW-1:0] m_xcnt;
    logic [2:0]    m_stat;
    string         ctx;

    always #10 clk = ~clk;

    pwm_timebase #(.CW(CW), .XW(XW)) u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_en(sync_en),
        .sync_in(sync_in), .tmr_rst(tmr_rst), .cnt_start(cnt_start),
        .cnt_reload(cnt_reload), .xcnt_start(xcnt_start), .xcnt_reload(xcnt_reload),
        .status_clr(status_clr), .irq_mask(irq_mask), .dma_mask(dma_mask),
        .cnt_o(cnt_o), .xcnt_o(xcnt_o), .status_o(status_o), .irq_o(irq_o), .dma_o(dma_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s (%s): actual %0d expected %0d", tag, what, ctx, act, exp);
        end
    endtask

    // bench reference model, one clock edge
    task automatic model_step();
        logic       hit;
        logic [2:0] setv;
        hit  = m_run && sync_en && sync_in && !m_syncq && !tmr_rst;
        setv = 3'b000;
        ctx  = m_run ? "run" : "halt";
        if (tmr_rst) begin
            m_cnt = cnt_start; m_xcnt = xcnt_start; ctx = "timer reset";
        end else if (hit) begin
            m_cnt = cnt_start; m_xcnt = xcnt_start; setv = 3'b101; ctx = "sync";
        end else if (m_run) begin
            if (m_cnt == (cnt_reload >> 1)) setv[1] = 1'b1;
            if (m_cnt >= cnt_reload) begin
                m_cnt = cnt_start; setv[0] = 1'b1;
                if (m_xcnt >= xcnt_reload) begin
                    m_xcnt = xcnt_start; setv[2] = 1'b1;
                end else begin
                    m_xcnt = m_xcnt + 1'b1;
                end
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
        end
        m_stat  = (m_stat & ~status_clr) | setv;
        m_syncq = sync_in;
        m_run   = run_en;
    endtask

    task automatic compare();
        string tc, tx;
        tc = (ctx == "sync") ? "R4" : (ctx == "timer reset") ? "R10" : (ctx == "halt") ? "R8" : "R1";
        tx = (ctx == "sync") ? "R4" : (ctx == "timer reset") ? "R10" : (ctx == "halt") ? "R8" : "R3";
        chk(tc, "cnt_o", int'(cnt_o), int'(m_cnt));
        chk(tx, "xcnt_o", int'(xcnt_o), int'(m_xcnt));
        chk((status_clr != 0) ? "R5" : "R1", "status bit0", int'(status_o[0]), int'(m_stat[0]));
        chk((status_clr != 0) ? "R5" : "R2", "status bit1", int'(status_o[1]), int'(m_stat[1]));
        chk((status_clr != 0) ? "R5" : "R3", "status bit2", int'(status_o[2]), int'(m_stat[2]));
        chk("R6", "irq_o", int'(irq_o), int'(|(m_stat & irq_mask)));
        chk("R7", "dma_o", int'(dma_o), int'(|(m_stat & dma_mask)));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..R10 run incomplete): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_run = 1'b0; m_syncq = 1'b0; m_cnt = '0; m_xcnt = '0; m_stat = '0; ctx = "reset";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", "cnt_o after reset", int'(cnt_o), 0);
        chk("R9", "xcnt_o after reset", int'(xcnt_o), 0);
        chk("R9", "status after reset", int'(status_o), 0);
        chk("R9", "irq_o after reset", int'(irq_o), 0);

        // directed: halted, sync ignored (R8)
        cnt_start = 16'd2; cnt_reload = 16'd6; xcnt_start = 4'd0; xcnt_reload = 4'd2;
        irq_mask = 3'b001; dma_mask = 3'b100; sync_en = 1'b1;
        sync_in = 1'b1; tick(); sync_in = 1'b0; tick();
        // directed: timer reset while halted (R10)
        tmr_rst = 1'b1; tick(); tmr_rst = 1'b0;
        // directed: run long enough for reloads, half and extended reload
        run_en = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        // directed: clear with simultaneous set (R5)
        status_clr = 3'b111;
        for (int i = 0; i < 6; i++) tick();
        status_clr = 3'b000;
        // directed: sync edge and timer reset collision (R4, R10)
        sync_in = 1'b1; tick(); sync_in = 1'b0; tick();
        sync_in = 1'b1; tmr_rst = 1'b1; tick(); sync_in = 1'b0; tmr_rst = 1'b0; tick();
        // directed: reload below current count, start above reload
        cnt_reload = 16'd0; tick(); tick();
        cnt_start = 16'd9; cnt_reload = 16'd3; for (int i = 0; i < 5; i++) tick();
        run_en = 1'b0; for (int i = 0; i < 4; i++) tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (i % 300 == 0) begin
                cnt_reload  = 16'($urandom % 16);
                cnt_start   = ($urandom % 8 == 0) ? 16'($urandom % 20) : 16'($urandom % (cnt_reload + 1));
                xcnt_reload = 4'($urandom % 5);
                xcnt_start  = 4'($urandom % (xcnt_reload + 1));
            end
            if (i % 50 == 0) begin
                irq_mask = 3'($urandom % 8);
                dma_mask = 3'($urandom % 8);
            end
            if (i % 200 == 0) sync_en = 1'($urandom % 2);
            run_en     = (($urandom % 16) != 0);
            sync_in    = (($urandom % 6) == 0);
            tmr_rst    = (($urandom % 64) == 0);
            status_clr = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'b000;
            tick();
        end
        summary();
        $finish;
    end
endmodule